// File: doc/BRIEF.md
# ADC Conversion Sequencer with Interrupt Loopback

This block sits between a set of trigger sources and an external analog-to-digital converter. Four numbered conversion slots each hold an input channel number, a sampling window length counted in clock cycles, and a trigger selection. When a slot's trigger fires, the slot is marked pending. Whenever the converter is idle, the lowest-numbered pending slot is started. The block drives the channel and holds the sample strobe high for the programmed window. It then issues a one-cycle start pulse and waits for the converter's done strobe. The returned data is stored in a result register for that slot.

Each slot can route its end of conversion to one of two interrupt lines. Each line keeps a sticky flag, and software clears the flag by writing 1 to an acknowledge bit. In continuous mode a line pulses on every routed end of conversion. Otherwise it stays quiet while its flag is set. A slot can also restart itself from the pulse of either interrupt line, which gives a free-running conversion loop. In non-continuous mode that loop stops when no one acknowledges the flag.

Software reaches the block through a single-cycle write strobe and a combinational read port. Addresses 0 to 3 hold the slot configuration. Addresses 4 to 7 hold the slot results. Address 8 holds the interrupt mode and flags, and address 9 is the acknowledge register.

Top module: `conv_sched`

## Requirements
- R1: After reset, all slot configurations, results, interrupt modes and flags read as zero, and sample_o, conv_start_o, eoc_o and irq_o are low.
- R2: A started slot drives its channel (config bits [3:0]) on conv_ch_o. sample_o is held high for exactly acq+1 cycles, where acq is config bits [15:8], and conv_ch_o is stable during that time. A single-cycle conv_start_o follows on the next cycle.
- R3: The trigger field (config bits [18:16]) selects the trigger: value k from 1 to N_EXT picks trig_i[k-1]. A value of 0, or any value above N_EXT, ignores every trig_i pulse for that slot.
- R4: conv_data_i is captured when conv_done_i arrives during the wait for a result, and is readable at address 4+slot. eoc_o is a one-cycle pulse with the slot number on eoc_slot_o.
- R5: Triggers that arrive while a conversion is in progress are held pending. Pending slots are served in ascending slot number.
- R6: The post field (config bits [25:24]) routes end of conversion to a line: 1 selects irq_o[0], 2 selects irq_o[1], and 0 or 3 selects no line. The routed line's flag is set and can be read at address 8 bits [9:8].
- R7: In non-continuous mode (address 8 bit l = 0), line l gives no pulse while its flag is set. Writing 1 to bit l at address 9 clears the flag.
- R8: In continuous mode (address 8 bit l = 1), line l pulses once for every end of conversion routed to it, whatever the state of its flag.
- R9: The loop field (config bits [21:20]) makes a slot pending on each pulse of the chosen line: 1 selects irq_o[0] and 2 selects irq_o[1]. A value of 0 disables the loop path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| trig_i | input | N_EXT | External trigger pulses |
| conv_ch_o | output | CH_W | Channel select to converter |
| sample_o | output | 1 | Sampling window active |
| conv_start_o | output | 1 | Start-of-conversion pulse |
| conv_done_i | input | 1 | Converter done strobe |
| conv_data_i | input | DATA_W | Converter result |
| eoc_o | output | 1 | End-of-conversion pulse |
| eoc_slot_o | output | 2 | Slot that just finished |
| irq_o | output | 2 | Interrupt pulses, line 1 on bit 0 |

## Verification
The bench builds the block with its default parameters: four slots, four external triggers, 4-bit channels, an 8-bit window and 12-bit data. With these values every slot can be swept across small window lengths and the full 255 window, and each result can be predicted from the channel number. Four slots are also enough to queue a full set of triggers behind a busy conversion and check the service order. Both interrupt lines can be driven in each mode, which lets the loop stop after exactly two conversions in one mode and run freely in the other.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_START, ST_WAIT} seq_st_e;
  localparam int N_LINES  = 2;
  localparam int ADDR_W   = 4;
  localparam int REG_W    = 32;
  localparam int CH_LSB   = 0;
  localparam int ACQ_LSB  = 8;
  localparam int TRIG_LSB = 16;
  localparam int LOOP_LSB = 20;
  localparam int POST_LSB = 24;
  localparam int RES_BASE = 4;
  localparam int CTRL_ADR = 8;
  localparam int ACK_ADR  = 9;
endpackage

// File: rtl/conv_sched_regs.sv
module conv_sched_regs
  import conv_sched_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int CH_W    = 4,
  parameter int ACQ_W   = 8,
  parameter int TRIG_W  = 3,
  parameter int DATA_W  = 12,
  parameter int SLOT_W  = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [REG_W-1:0]                  wdata_i,
  output logic [REG_W-1:0]                  rdata_o,
  input  logic                              eoc_i,
  input  logic [SLOT_W-1:0]                 eoc_slot_i,
  input  logic [DATA_W-1:0]                 eoc_data_i,
  input  logic [N_LINES-1:0]                flag_i,
  output logic [N_SLOTS-1:0][CH_W-1:0]      cfg_ch_o,
  output logic [N_SLOTS-1:0][ACQ_W-1:0]     cfg_acq_o,
  output logic [N_SLOTS-1:0][TRIG_W-1:0]    cfg_trig_o,
  output logic [N_SLOTS-1:0][1:0]           cfg_loop_o,
  output logic [N_SLOTS-1:0][1:0]           cfg_post_o,
  output logic [N_LINES-1:0]                cont_o,
  output logic [N_LINES-1:0]                ack_o
);
  logic [N_SLOTS-1:0][DATA_W-1:0] res_q;
  logic [N_LINES-1:0]             cont_q;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_ch_o[i]   <= '0;
        cfg_acq_o[i]  <= '0;
        cfg_trig_o[i] <= '0;
        cfg_loop_o[i] <= '0;
        cfg_post_o[i] <= '0;
      end else if (we_i && addr_i == ADDR_W'(i)) begin
        cfg_ch_o[i]   <= wdata_i[CH_LSB +: CH_W];
        cfg_acq_o[i]  <= wdata_i[ACQ_LSB +: ACQ_W];
        cfg_trig_o[i] <= wdata_i[TRIG_LSB +: TRIG_W];
        cfg_loop_o[i] <= wdata_i[LOOP_LSB +: 2];
        cfg_post_o[i] <= wdata_i[POST_LSB +: 2];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  res_q[i] <= '0;
      else if (eoc_i && eoc_slot_i == SLOT_W'(i))   res_q[i] <= eoc_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cont_q <= '0;
    else if (we_i && addr_i == ADDR_W'(CTRL_ADR))  cont_q <= wdata_i[N_LINES-1:0];
  end

  assign cont_o = cont_q;
  assign ack_o  = (we_i && addr_i == ADDR_W'(ACK_ADR)) ? wdata_i[N_LINES-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (addr_i == ADDR_W'(i)) begin
        rdata_o[CH_LSB +: CH_W]     = cfg_ch_o[i];
        rdata_o[ACQ_LSB +: ACQ_W]   = cfg_acq_o[i];
        rdata_o[TRIG_LSB +: TRIG_W] = cfg_trig_o[i];
        rdata_o[LOOP_LSB +: 2]      = cfg_loop_o[i];
        rdata_o[POST_LSB +: 2]      = cfg_post_o[i];
      end
      if (addr_i == ADDR_W'(RES_BASE + i)) rdata_o[DATA_W-1:0] = res_q[i];
    end
    if (addr_i == ADDR_W'(CTRL_ADR)) begin
      rdata_o[N_LINES-1:0]   = cont_q;
      rdata_o[8 +: N_LINES]  = flag_i;
    end
  end
endmodule

// File: rtl/conv_sched_arb.sv
module conv_sched_arb
  import conv_sched_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int N_EXT   = 4,
  parameter int TRIG_W  = 3,
  parameter int SLOT_W  = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_EXT-1:0]               trig_i,
  input  logic [N_LINES-1:0]             irq_i,
  input  logic [N_SLOTS-1:0][TRIG_W-1:0] cfg_trig_i,
  input  logic [N_SLOTS-1:0][1:0]        cfg_loop_i,
  input  logic                           take_i,
  output logic                           req_v_o,
  output logic [SLOT_W-1:0]              req_slot_o
);
  logic [N_SLOTS-1:0] pend_q, set, clr;

  always_comb begin
    set = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      for (int k = 0; k < N_EXT; k++)
        if (cfg_trig_i[i] == TRIG_W'(k + 1) && trig_i[k]) set[i] = 1'b1;
      for (int l = 0; l < N_LINES; l++)
        if (cfg_loop_i[i] == 2'(l + 1) && irq_i[l]) set[i] = 1'b1;
    end
  end

  always_comb begin
    req_v_o    = 1'b0;
    req_slot_o = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        req_v_o    = 1'b1;
        req_slot_o = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    clr = '0;
    if (take_i) clr[req_slot_o] = 1'b1;
  end

  // a fresh trigger in the grant cycle stays pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr) | set;
  end

  a_r5_lowest_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> ((pend_q & ((N_SLOTS'(1) << req_slot_o) - N_SLOTS'(1))) == '0)
                && pend_q[req_slot_o]);
endmodule

// File: rtl/conv_sched_fsm.sv
module conv_sched_fsm
  import conv_sched_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int CH_W    = 4,
  parameter int ACQ_W   = 8,
  parameter int DATA_W  = 12,
  parameter int SLOT_W  = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_v_i,
  input  logic [SLOT_W-1:0]             req_slot_i,
  input  logic [N_SLOTS-1:0][CH_W-1:0]  cfg_ch_i,
  input  logic [N_SLOTS-1:0][ACQ_W-1:0] cfg_acq_i,
  output logic                          take_o,
  output logic [CH_W-1:0]               conv_ch_o,
  output logic                          sample_o,
  output logic                          conv_start_o,
  input  logic                          conv_done_i,
  input  logic [DATA_W-1:0]             conv_data_i,
  output logic                          eoc_o,
  output logic [SLOT_W-1:0]             eoc_slot_o,
  output logic [DATA_W-1:0]             eoc_data_o
);
  seq_st_e           st_q;
  logic [ACQ_W-1:0]  cnt_q;
  logic [SLOT_W-1:0] slot_q;
  logic [CH_W-1:0]   ch_q;

  assign take_o       = (st_q == ST_IDLE) && req_v_i;
  assign sample_o     = (st_q == ST_SAMPLE);
  assign conv_start_o = (st_q == ST_START);
  assign conv_ch_o    = ch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      slot_q     <= '0;
      ch_q       <= '0;
      eoc_o      <= 1'b0;
      eoc_slot_o <= '0;
      eoc_data_o <= '0;
    end else begin
      eoc_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (take_o) begin
          slot_q <= req_slot_i;
          ch_q   <= cfg_ch_i[req_slot_i];
          cnt_q  <= cfg_acq_i[req_slot_i];
          st_q   <= ST_SAMPLE;
        end
        ST_SAMPLE: begin
          if (cnt_q == '0) st_q  <= ST_START;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_START: st_q <= ST_WAIT;
        ST_WAIT: if (conv_done_i) begin
          eoc_o      <= 1'b1;
          eoc_slot_o <= slot_q;
          eoc_data_o <= conv_data_i;
          st_q       <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r2_start_after_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> $past(sample_o));
  a_r2_ch_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && $past(sample_o)) |-> $stable(conv_ch_o));
  a_r4_eoc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> !eoc_o);
endmodule

// File: rtl/conv_sched_irq.sv
module conv_sched_irq
  import conv_sched_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               eoc_i,
  input  logic [1:0]         post_i,
  input  logic [N_LINES-1:0] cont_i,
  input  logic [N_LINES-1:0] ack_i,
  output logic [N_LINES-1:0] irq_o,
  output logic [N_LINES-1:0] flag_o
);
  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    logic hit;
    assign hit = eoc_i && post_i == 2'(l + 1);

    // a new event wins over an acknowledge in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        irq_o[l]  <= 1'b0;
        flag_o[l] <= 1'b0;
      end else begin
        irq_o[l] <= hit && (cont_i[l] || !flag_o[l]);
        if (hit)           flag_o[l] <= 1'b1;
        else if (ack_i[l]) flag_o[l] <= 1'b0;
      end
    end

    a_r7_noncont_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cont_i[l] && flag_o[l]) |=> !irq_o[l]);
    a_r6_flag_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[l] |-> flag_o[l]);
  end
endmodule

// File: rtl/conv_sched.sv
module conv_sched
  import conv_sched_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int N_EXT   = 4,
  parameter int CH_W    = 4,
  parameter int ACQ_W   = 8,
  parameter int DATA_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [N_EXT-1:0]  trig_i,
  output logic [CH_W-1:0]   conv_ch_o,
  output logic              sample_o,
  output logic              conv_start_o,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              eoc_o,
  output logic [1:0]        eoc_slot_o,
  output logic [1:0]        irq_o
);
  localparam int TRIG_W = $clog2(N_EXT + 1);
  localparam int SLOT_W = 2;

  logic [N_SLOTS-1:0][CH_W-1:0]   cfg_ch;
  logic [N_SLOTS-1:0][ACQ_W-1:0]  cfg_acq;
  logic [N_SLOTS-1:0][TRIG_W-1:0] cfg_trig;
  logic [N_SLOTS-1:0][1:0]        cfg_loop, cfg_post;
  logic [N_LINES-1:0]             cont, ack, flag;
  logic                           req_v, take;
  logic [SLOT_W-1:0]              req_slot;
  logic [DATA_W-1:0]              eoc_data;

  conv_sched_regs #(.N_SLOTS(N_SLOTS), .CH_W(CH_W), .ACQ_W(ACQ_W), .TRIG_W(TRIG_W),
                    .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .eoc_i(eoc_o), .eoc_slot_i(eoc_slot_o), .eoc_data_i(eoc_data),
    .flag_i(flag), .cfg_ch_o(cfg_ch), .cfg_acq_o(cfg_acq), .cfg_trig_o(cfg_trig),
    .cfg_loop_o(cfg_loop), .cfg_post_o(cfg_post), .cont_o(cont), .ack_o(ack));

  conv_sched_arb #(.N_SLOTS(N_SLOTS), .N_EXT(N_EXT), .TRIG_W(TRIG_W), .SLOT_W(SLOT_W)) u_arb (
    .clk_i, .rst_ni, .trig_i, .irq_i(irq_o), .cfg_trig_i(cfg_trig), .cfg_loop_i(cfg_loop),
    .take_i(take), .req_v_o(req_v), .req_slot_o(req_slot));

  conv_sched_fsm #(.N_SLOTS(N_SLOTS), .CH_W(CH_W), .ACQ_W(ACQ_W), .DATA_W(DATA_W),
                   .SLOT_W(SLOT_W)) u_fsm (
    .clk_i, .rst_ni, .req_v_i(req_v), .req_slot_i(req_slot), .cfg_ch_i(cfg_ch),
    .cfg_acq_i(cfg_acq), .take_o(take), .conv_ch_o, .sample_o, .conv_start_o,
    .conv_done_i, .conv_data_i, .eoc_o, .eoc_slot_o, .eoc_data_o(eoc_data));

  conv_sched_irq u_irq (
    .clk_i, .rst_ni, .eoc_i(eoc_o), .post_i(cfg_post[eoc_slot_o]), .cont_i(cont),
    .ack_i(ack), .irq_o, .flag_o(flag));

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sample_o) |-> !conv_start_o);
endmodule

// File: tb/sim_conv_sched.sv
module sim_conv_sched;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0]  trig = '0;
  logic [3:0]  ch;
  logic        sample, start, done, eoc;
  logic [11:0] data;
  logic [1:0]  eoc_slot, irq;

  int n_chk = 0, n_err = 0;
  int n_eoc = 0, n_irq0 = 0, n_irq1 = 0, eoc_dbl = 0;
  int cur_w = 0, last_w = 0, last_ch = 0;
  int eoc_log [0:255];
  logic prev_s = 1'b0, prev_e = 1'b0;
  int   cvt_cnt = 0;

  always #4 clk = ~clk;

  conv_sched u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .trig_i(trig), .conv_ch_o(ch), .sample_o(sample),
    .conv_start_o(start), .conv_done_i(done), .conv_data_i(data), .eoc_o(eoc),
    .eoc_slot_o(eoc_slot), .irq_o(irq));

  // converter model: done three cycles after start, data derived from channel
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cvt_cnt <= 0; done <= 1'b0; data <= '0;
    end else begin
      if (start)            cvt_cnt <= 3;
      else if (cvt_cnt != 0) cvt_cnt <= cvt_cnt - 1;
      done <= (cvt_cnt == 1);
      data <= 12'(int'(ch) * 100 + 7);
    end
  end

  always @(negedge clk) begin
    if (sample) begin cur_w = cur_w + 1; last_ch = int'(ch); end
    if (!sample && prev_s) begin last_w = cur_w; cur_w = 0; end
    if (eoc) begin
      if (prev_e) eoc_dbl = eoc_dbl + 1;
      eoc_log[n_eoc % 256] = int'(eoc_slot);
      n_eoc = n_eoc + 1;
    end
    if (irq[0]) n_irq0 = n_irq0 + 1;
    if (irq[1]) n_irq1 = n_irq1 + 1;
    prev_s = sample;
    prev_e = eoc;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_err = n_err + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); addr = 4'(a); #1 d = rdata;
  endtask

  task automatic pulse(input logic [3:0] t);
    @(negedge clk); trig = t;
    @(negedge clk); trig = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_eoc(input int target);
    for (int i = 0; i < 3000 && n_eoc < target; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] cfg(input int c, input int acq, input int tsel,
                                      input int lp, input int post);
    return 32'(c) | (32'(acq) << 8) | (32'(tsel) << 16) | (32'(lp) << 20) | (32'(post) << 24);
  endfunction

  initial begin
    #(8 * 150000);
    n_err = n_err + 1;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int base, bi0, bi1;
    idle(3); rst_n = 1'b1; idle(2);

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(a, r); chk("R1 reg", int'(r), 0);
    end
    chk("R1 outs", int'({sample, start, eoc, irq}), 0);

    // R2 R4: sweep every slot over window lengths
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 9; k++) begin
        int acq, c;
        acq = (k == 8) ? 255 : k;
        c = (s * 5 + k) % 16;
        wr(s, cfg(c, acq, s + 1, 0, 0));
        base = n_eoc;
        pulse(4'(1 << s));
        wait_eoc(base + 1);
        idle(2);
        chk("R2 width", last_w, acq + 1);
        chk("R2 channel", last_ch, c);
        chk("R4 eoc slot", eoc_log[base % 256], s);
        rd(4 + s, r); chk("R4 result", int'(r), c * 100 + 7);
      end
    end

    // R5 queued triggers served in ascending order
    for (int s = 0; s < 4; s++) wr(s, cfg(s + 1, 4, s + 1, 0, 0));
    base = n_eoc;
    pulse(4'b0001);
    idle(1);
    pulse(4'b1110);
    wait_eoc(base + 4); idle(2);
    chk("R5 count", n_eoc - base, 4);
    for (int i = 0; i < 4; i++) chk("R5 order", eoc_log[(base + i) % 256], i);

    // R3 disabled and out-of-range trigger selections
    wr(0, cfg(1, 1, 0, 0, 0));
    wr(1, cfg(2, 1, 7, 0, 0));
    wr(2, cfg(3, 1, 5, 0, 0));
    base = n_eoc;
    pulse(4'b1111);
    idle(40);
    chk("R3 ignored", n_eoc - base, 1); // only slot 3 with tsel 4
    chk("R3 which", eoc_log[base % 256], 3);
    // R3 slot 0 picks trig_i[2] when tsel=3
    wr(0, cfg(9, 0, 3, 0, 0)); wr(3, cfg(4, 1, 0, 0, 0));
    base = n_eoc;
    pulse(4'b0100); wait_eoc(base + 1); idle(2);
    chk("R3 mapped", eoc_log[base % 256], 0);

    // R6 R7 non-continuous line 1
    wr(8, 0); wr(9, 3);
    wr(0, cfg(2, 1, 1, 0, 1));
    bi0 = n_irq0; bi1 = n_irq1; base = n_eoc;
    pulse(4'b0001); wait_eoc(base + 1); idle(3);
    chk("R6 irq0", n_irq0 - bi0, 1);
    chk("R6 irq1 quiet", n_irq1 - bi1, 0);
    rd(8, r); chk("R6 flag", int'(r[9:8]), 1);
    pulse(4'b0001); wait_eoc(base + 2); idle(3);
    chk("R7 blocked", n_irq0 - bi0, 1);
    wr(9, 1);
    rd(8, r); chk("R7 ack", int'(r[9:8]), 0);
    pulse(4'b0001); wait_eoc(base + 3); idle(3);
    chk("R7 after ack", n_irq0 - bi0, 2);
    // R6 post code 3 routes nowhere
    wr(9, 3); wr(0, cfg(2, 1, 1, 0, 3));
    bi0 = n_irq0; bi1 = n_irq1; base = n_eoc;
    pulse(4'b0001); wait_eoc(base + 1); idle(3);
    chk("R6 none", (n_irq0 - bi0) + (n_irq1 - bi1), 0);
    rd(8, r); chk("R6 none flag", int'(r[9:8]), 0);

    // R8 continuous line 2
    wr(8, 2);
    wr(1, cfg(5, 2, 2, 0, 2));
    bi1 = n_irq1; base = n_eoc;
    for (int i = 0; i < 3; i++) begin
      pulse(4'b0010); wait_eoc(base + i + 1); idle(3);
    end
    chk("R8 every eoc", n_irq1 - bi1, 3);
    rd(8, r); chk("R8 mode flag", int'(r), 32'h202);

    // R9 loop in non-continuous mode stops after two conversions
    wr(8, 0); wr(9, 3);
    wr(2, cfg(6, 2, 3, 1, 1));
    bi0 = n_irq0; base = n_eoc;
    pulse(4'b0100); idle(200);
    chk("R9 loop stop", n_eoc - base, 2);
    chk("R9 loop irq", n_irq0 - bi0, 1);

    // R9 loop in continuous mode runs until the loop field is cleared
    wr(8, 1); wr(9, 3);
    base = n_eoc;
    pulse(4'b0100); idle(300);
    chk("R9 free run", int'((n_eoc - base) >= 10), 1);
    wr(2, cfg(6, 2, 3, 0, 1));
    idle(60);
    base = n_eoc;
    idle(150);
    chk("R9 loop off", n_eoc - base, 0);

    chk("R4 single eoc", eoc_dbl, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule